// File: doc/BRIEF.md
# Dual GPIO Port with Pin-Change Wake

This block controls two banks of bidirectional tri-state pins. Each pin has a direction bit that makes it an input or an output. Each bank also has an output latch and a read path that returns the synchronized pin level. Bank A adds per-pin pull-up and pull-down enables, which the pad ring uses. Bank A also watches its input pins for a level change. Bank B adds a per-pin open-drain output mode.

Software reaches every register over a flat register bus with a 3-bit address. Writes take effect on the clock edge. Read data is combinational from the address. A read strobe on bank A's data address stores the current synchronized pin levels as a reference snapshot. An input pin of bank A whose synchronized level differs from that snapshot sets a sticky change flag. The flag drives a wake request at all times, and it drives an interrupt when the interrupt enable is set.

Top module: `gpio_port_pair`

## Requirements
- R1: After reset, every direction bit is 1 (all pins are inputs), so `pa_oe_o` and `pb_oe_o` are 0. The output latches, pull enables, open-drain bits, interrupt enable and change flag are all 0. `irq_o` and `wake_o` are low.
- R2: A direction bit of 0 makes the pin an output, with output enable 1 and its latch bit on the pin output. A direction bit of 1 sets output enable to 0. The change shows at the ports right after the write edge.
- R3: Addresses 1 (bank A direction), 3 (bank B direction), 4 (bank A pull-up), 5 (bank A pull-down) and 6 (bank B open-drain) read back the value last written to them. Address 7 (control) reads bit 1 = interrupt enable and bit 0 = change flag, with the upper bits 0.
- R4: Address 0 reads bank A pins and address 2 reads bank B pins. Both pass through a two-flop synchronizer, so a read never returns the output latch. A pin change is visible on `rdata_o` after the second rising edge that follows it.
- R5: `pa_pu_o` equals the pull-up register ANDed with bank A's direction bits. A pull is active only on input pins.
- R6: `pa_pd_o` equals the pull-down register ANDed with the direction bits and with the inverse of the pull-up register. Pull-up wins, so both pulls are never on for one pin.
- R7: On bank B, a pin with its open-drain bit set and latch 1 has output enable 0. The same pin with latch 0 has output enable 1 and output 0. Pins with the open-drain bit clear drive push-pull.
- R8: The change flag sets on the third rising edge after a bank A input pin (direction 1) changes level against the snapshot. Level changes on output pins (direction 0) never set it.
- R9: A read of address 0 with `rd_en_i` high stores the synchronized bank A levels as the new snapshot, so levels already seen raise no further change.
- R10: The change flag stays set until software writes 1 to control bit 0. Such a write leaves the flag set while an unsnapshotted input mismatch remains.
- R11: `irq_o` is the change flag gated by interrupt enable (control bit 1). `wake_o` follows the change flag whatever the interrupt enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (snapshots bank A on address 0) |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for `addr_i` |
| pa_in_i | input | W | Bank A pin levels |
| pa_out_o | output | W | Bank A pin output values |
| pa_oe_o | output | W | Bank A output enables |
| pa_pu_o | output | W | Bank A pull-up enables to pads |
| pa_pd_o | output | W | Bank A pull-down enables to pads |
| pb_in_i | input | W | Bank B pin levels |
| pb_out_o | output | W | Bank B pin output values |
| pb_oe_o | output | W | Bank B output enables |
| irq_o | output | 1 | Pin-change interrupt |
| wake_o | output | 1 | Pin-change wake request |

## Verification
Register writes and the pin-control outputs derived from them are due right after the write edge. The bench therefore drives on a falling edge and checks on the next falling edge. A pin level reaches `rdata_o` after two rising edges and the change flag after three. The bench steps the falling edges one at a time and checks the old value before the due edge and the new value after it. Read data is combinational, so the bench samples it shortly after it sets the address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    ADDR_A_DATA = 3'd0,
    ADDR_A_DIR  = 3'd1,
    ADDR_B_DATA = 3'd2,
    ADDR_B_DIR  = 3'd3,
    ADDR_A_PU   = 3'd4,
    ADDR_A_PD   = 3'd5,
    ADDR_B_OD   = 3'd6,
    ADDR_CTRL   = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_FLAG_BIT = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned NUM_ADDR      = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] a_data_o,
  output logic [W-1:0] a_dir_o,
  output logic [W-1:0] b_data_o,
  output logic [W-1:0] b_dir_o,
  output logic [W-1:0] a_pu_o,
  output logic [W-1:0] a_pd_o,
  output logic [W-1:0] b_od_o,
  output logic         ie_o,
  output logic         clr_o
);
  localparam int unsigned NREG = NUM_ADDR - 1;

  logic [W-1:0] regs_q [NREG];
  logic         ie_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [W-1:0] RST_VAL =
      (i == int'(ADDR_A_DIR) || i == int'(ADDR_B_DIR)) ? '1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[i] <= RST_VAL;
      else if (wr_en_i && addr_i == 3'(i))       regs_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ie_q <= 1'b0;
    else if (wr_en_i && addr_i == ADDR_CTRL)     ie_q <= wdata_i[CTRL_IE_BIT];
  end

  assign a_data_o = regs_q[ADDR_A_DATA];
  assign a_dir_o  = regs_q[ADDR_A_DIR];
  assign b_data_o = regs_q[ADDR_B_DATA];
  assign b_dir_o  = regs_q[ADDR_B_DIR];
  assign a_pu_o   = regs_q[ADDR_A_PU];
  assign a_pd_o   = regs_q[ADDR_A_PD];
  assign b_od_o   = regs_q[ADDR_B_OD];
  assign ie_o     = ie_q;
  assign clr_o    = wr_en_i && (addr_i == ADDR_CTRL) && wdata_i[CTRL_FLAG_BIT];
endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] watch_i,
  input  logic         snap_i,
  input  logic         clr_i,
  output logic         chg_o,
  output logic         flag_o
);
  logic [W-1:0] snap_q;
  logic         flag_q;

  assign chg_o = |((lvl_i ^ snap_q) & watch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (snap_i) snap_q <= lvl_i;
      // a live mismatch outranks a clear
      flag_q <= (flag_q && !clr_i) || chg_o;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] od_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (od_i[i]) begin
        out_o[i] = 1'b0;
        oe_o[i]  = !dir_i[i] && !data_i[i];
      end else begin
        out_o[i] = data_i[i];
        oe_o[i]  = !dir_i[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port_pair.sv
module gpio_port_pair
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   addr_i,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pa_in_i,
  output logic [W-1:0] pa_out_o,
  output logic [W-1:0] pa_oe_o,
  output logic [W-1:0] pa_pu_o,
  output logic [W-1:0] pa_pd_o,
  input  logic [W-1:0] pb_in_i,
  output logic [W-1:0] pb_out_o,
  output logic [W-1:0] pb_oe_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [W-1:0] a_data, dir_a, b_data, dir_b, pu_a, pd_a, od_b;
  logic [W-1:0] a_lvl, b_lvl;
  logic         ie, clr, chg_any, flag;

  gpio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .a_data_o(a_data), .a_dir_o(dir_a), .b_data_o(b_data), .b_dir_o(dir_b),
    .a_pu_o(pu_a), .a_pd_o(pd_a), .b_od_o(od_b), .ie_o(ie), .clr_o(clr)
  );

  gpio_sync #(.W(W)) u_sync_a (.clk_i, .rst_ni, .d_i(pa_in_i), .q_o(a_lvl));
  gpio_sync #(.W(W)) u_sync_b (.clk_i, .rst_ni, .d_i(pb_in_i), .q_o(b_lvl));

  gpio_change_det #(.W(W)) u_chg (
    .clk_i, .rst_ni, .lvl_i(a_lvl), .watch_i(dir_a),
    .snap_i(rd_en_i && addr_i == ADDR_A_DATA), .clr_i(clr),
    .chg_o(chg_any), .flag_o(flag)
  );

  gpio_pin_drv #(.W(W)) u_drv_a (
    .data_i(a_data), .dir_i(dir_a), .od_i('0), .out_o(pa_out_o), .oe_o(pa_oe_o)
  );
  gpio_pin_drv #(.W(W)) u_drv_b (
    .data_i(b_data), .dir_i(dir_b), .od_i(od_b), .out_o(pb_out_o), .oe_o(pb_oe_o)
  );

  assign pa_pu_o = pu_a & dir_a;
  assign pa_pd_o = pd_a & dir_a & ~pu_a;

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      ADDR_A_DATA: rdata_o = a_lvl;
      ADDR_A_DIR:  rdata_o = dir_a;
      ADDR_B_DATA: rdata_o = b_lvl;
      ADDR_B_DIR:  rdata_o = dir_b;
      ADDR_A_PU:   rdata_o = pu_a;
      ADDR_A_PD:   rdata_o = pd_a;
      ADDR_B_OD:   rdata_o = od_b;
      ADDR_CTRL: begin
        rdata_o[CTRL_FLAG_BIT] = flag;
        rdata_o[CTRL_IE_BIT]   = ie;
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_o  = flag && ie;
  assign wake_o = flag;
endmodule

// File: rtl/gpio_port_pair_chk.sv
module gpio_port_pair_chk
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   addr_i,
  input logic         wr_en_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] pa_oe_o,
  input logic [W-1:0] pa_pu_o,
  input logic [W-1:0] pa_pd_o,
  input logic [W-1:0] pb_out_o,
  input logic [W-1:0] pb_oe_o,
  input logic [W-1:0] dir_a,
  input logic [W-1:0] od_b,
  input logic         chg_any,
  input logic         irq_o,
  input logic         wake_o
);
  logic clr_wr;
  assign clr_wr = wr_en_i && addr_i == ADDR_CTRL && wdata_i[CTRL_FLAG_BIT];

  AST_DIR_WRITE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_A_DIR) |=> (pa_oe_o == ~$past(wdata_i))); // R2
  AST_PU_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_A_PU) |=> (pa_pu_o == ($past(wdata_i) & dir_a))); // R5
  AST_PULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_pu_o & pa_pd_o) == '0); // R6
  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pb_oe_o & pb_out_o & od_b) == '0); // R7
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(chg_any)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !clr_wr) |=> wake_o); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !chg_any) |=> !wake_o); // R10
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o); // R11
endmodule

bind gpio_port_pair gpio_port_pair_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .pa_oe_o(pa_oe_o), .pa_pu_o(pa_pu_o), .pa_pd_o(pa_pd_o),
  .pb_out_o(pb_out_o), .pb_oe_o(pb_oe_o), .dir_a(dir_a), .od_b(od_b),
  .chg_any(chg_any), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/gpio_port_pair_test.sv
module gpio_port_pair_test;
  localparam int unsigned W = 8;
  localparam int unsigned NVEC = 14;
  // {addr, write data, expected read}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd1, 8'hA5, 8'hA5}, {3'd3, 8'h0F, 8'h0F}, {3'd4, 8'h33, 8'h33},
    {3'd5, 8'h3C, 8'h3C}, {3'd6, 8'hF0, 8'hF0}, {3'd7, 8'h02, 8'h02},
    {3'd7, 8'h00, 8'h00}, {3'd2, 8'h55, 8'hC3}, {3'd0, 8'h99, 8'h00},
    {3'd1, 8'hFF, 8'hFF}, {3'd3, 8'hFF, 8'hFF}, {3'd4, 8'h00, 8'h00},
    {3'd5, 8'h00, 8'h00}, {3'd6, 8'h00, 8'h00}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   addr_i = '0;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [W-1:0] wdata_i = '0, rdata_o;
  logic [W-1:0] pa_in_i = '0, pa_out_o, pa_oe_o, pa_pu_o, pa_pd_o;
  logic [W-1:0] pb_in_i = 8'hC3, pb_out_o, pb_oe_o;
  logic         irq_o, wake_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  gpio_port_pair #(.W(W)) uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 pa_oe", pa_oe_o, 8'h00);
    chk("R1 pb_oe", pb_oe_o, 8'h00);
    chk("R1 pa_out", pa_out_o, 8'h00);
    chk("R1 pulls", pa_pu_o | pa_pd_o, 8'h00);
    chk("R1 irq/wake", {6'd0, irq_o, wake_o}, 8'h00);
    rd(3'd1, r); chk("R1 dir A", r, 8'hFF);
    rd(3'd7, r); chk("R1 ctrl", r, 8'h00);
    repeat (2) @(negedge clk_i);

    // R3 readback, R4 data reads return pins
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], r);
      chk((VEC[i][18:16] inside {3'd0, 3'd2}) ? "R4 pin read" : "R3 readback",
          r, VEC[i][7:0]);
    end

    // R2 direction
    wr(3'd1, 8'h0F);
    chk("R2 pa_oe", pa_oe_o, 8'hF0);
    chk("R2 pa_out", pa_out_o, 8'h99);

    // R5 / R6 pulls
    wr(3'd4, 8'h33);
    wr(3'd5, 8'h3C);
    chk("R5 pull-up", pa_pu_o, 8'h03);
    chk("R6 pull-down", pa_pd_o, 8'h0C);

    // R7 open drain
    wr(3'd3, 8'h00);
    chk("R7 push-pull oe", pb_oe_o, 8'hFF);
    chk("R7 push-pull out", pb_out_o, 8'h55);
    wr(3'd6, 8'h0F);
    chk("R7 od oe", pb_oe_o, 8'hFA);
    chk("R7 od out", pb_out_o, 8'h50);

    // R8 output pin change ignored
    wr(3'd7, 8'h02);
    @(negedge clk_i); addr_i = 3'd0;
    pa_in_i = 8'h80;
    repeat (4) @(negedge clk_i);
    chk("R8 output pin ignored", {7'd0, wake_o}, 8'h00);
    // R8 input pin change, R4 two-edge latency
    pa_in_i = 8'h81;
    @(negedge clk_i);
    chk("R4 before due", rdata_o, 8'h80);
    chk("R8 not yet", {7'd0, wake_o}, 8'h00);
    @(negedge clk_i);
    chk("R4 due", rdata_o, 8'h81);
    chk("R8 not yet", {7'd0, wake_o}, 8'h00);
    @(negedge clk_i);
    chk("R8 flag set", {6'd0, irq_o, wake_o}, 8'h03);

    // R10 clear ignored while mismatch remains
    wr(3'd7, 8'h03);
    chk("R10 clear blocked", {7'd0, wake_o}, 8'h01);
    // R9 snapshot on read, then clear works
    rd(3'd0, r);
    wr(3'd7, 8'h03);
    chk("R10 cleared", {6'd0, irq_o, wake_o}, 8'h00);
    repeat (3) @(negedge clk_i);
    chk("R9 no re-trigger", {7'd0, wake_o}, 8'h00);

    // R11 wake without interrupt enable
    wr(3'd7, 8'h00);
    pa_in_i = 8'h83;
    repeat (3) @(negedge clk_i);
    chk("R11 wake only", {6'd0, irq_o, wake_o}, 8'h01);
    wr(3'd7, 8'h02);
    chk("R11 irq enabled", {6'd0, irq_o, wake_o}, 8'h03);
    rd(3'd7, r); chk("R3 ctrl status", r, 8'h03);

    finish_run();
  end
endmodule